// File: doc/BRIEF.md
# Fault-Map Steered Memory Request Router

This block sits between a last-level cache and a DRAM port. It accepts one read or write at a time on a byte address. Memory is arranged as 64-byte lines of eight 8-byte words. Each line has a 4-bit fault descriptor. Descriptors are packed 128 to a 64-byte fault-map line in a dedicated memory region. The block keeps a small direct-mapped cache of fault-map lines. When a request misses that cache, the block fetches the fault-map line from memory before it touches any data.

Once the descriptor is known, the access is steered. A word that the descriptor marks as replicated has been retired in main memory. Reads of such a word are served from its replica, and writes to it go to both copies, main copy first. Every other access goes to main memory alone. The replica location is not computed here. A helper port takes the line address and word index and returns the replica's byte address combinationally.

Read data returns on a response channel together with the request's tag. Writes give no response. All channels use valid/ready, and the memory port carries one command at a time.

Top module: `fmap_steer`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `mem_valid` and `rsp_valid` are 0.
- R2: The line address is `req_addr[31:6]`. The fault-map line number is the line address shifted right by 7. A fetch reads byte address `FM_BASE + 64*number`. The descriptor sits in bits `[4*s+3:4*s]` of the returned 512-bit line, where `s` is the line address's low 7 bits.
- R3: On a fault-map cache miss, exactly one memory read of the fault-map line is issued, and it completes before any data command. On a hit, no fetch is issued.
- R4: The fault-map cache is direct-mapped with 8 sets. The set is the fault-map line number's low 3 bits and the tag is its remaining bits. A fill replaces the set's previous line, so a conflicting line evicts it.
- R5: Descriptor encoding: bit 3 is the replicated flag, and bits 2:0 are the replicated word's index. A word is replicated only when the flag is 1 and the index equals `req_addr[5:3]`.
- R6: A read of a non-replicated word issues a single read at the word address (`req_addr` with bits 2:0 cleared). It returns bits 63:0 of `mem_rdata`.
- R7: A read of a replicated word issues a single read at `rep_addr` and never reads main memory. `rep_line` equals the line address and `rep_word` equals `req_addr[5:3]`.
- R8: A write to a non-replicated word issues exactly one write, at the word address, and produces no response.
- R9: A write to a replicated word issues two writes with the same data: first the word address, then `rep_addr`.
- R10: A read response carries the request's tag. `rsp_rdata` and `rsp_tag` hold steady while `rsp_valid` is 1 and `rsp_ready` is 0.
- R11: A memory command holds address, direction and data while `mem_valid` is 1 and `mem_ready` is 0. `req_ready` is 1 only when no request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Write data |
| req_tag | input | 4 | Request tag |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 64 | Read data |
| rsp_tag | output | 4 | Tag of the answered read |
| rep_line | output | 26 | Line address sent to the replica helper |
| rep_word | output | 3 | Word index sent to the replica helper |
| rep_addr | input | 32 | Replica byte address from the helper |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_write | output | 1 | Memory command is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rready | output | 1 | Block ready for read data |
| mem_rdata | input | 512 | Read data (word reads use bits 63:0) |

## Verification
A request accepted at clock edge 0 that hits the fault-map cache raises its memory command after edge 1. A miss first raises the fetch after edge 1, and the data command follows one lookup cycle after the fetch data is taken. A read response rises on the edge after read data is taken, and a replicated write's second command follows the edge at which the first is accepted. Because `mem_ready`, `mem_rvalid` and `rsp_ready` stall at random, the bench does not count fixed cycles. It drives all inputs at the falling edge and logs each handshake there, just before the rising edge that completes it. It compares the logged fetches, command order, addresses, data and tags with its own model once the block reports idle again.

// File: rtl/fmap_steer_pkg.sv
package fmap_steer_pkg;

  // width of one per-line fault descriptor
  localparam int ENT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FMREQ,
    ST_FMWAIT,
    ST_RDREQ,
    ST_RDWAIT,
    ST_RSP,
    ST_WRMAIN,
    ST_WRREP
  } st_e;

endpackage

// File: rtl/fmap_cache.sv
module fmap_cache #(
  parameter int SETS   = 8,
  parameter int CTAG_W = 16,
  parameter int LINE_W = 512,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_i,
  input  logic [CTAG_W-1:0] tag_i,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o
);

  logic [SETS-1:0]              vld_all;
  logic [SETS-1:0][CTAG_W-1:0]  tag_all;
  logic [SETS-1:0][LINE_W-1:0]  dat_all;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic              v_q;
    logic [CTAG_W-1:0] t_q;
    logic [LINE_W-1:0] d_q;
    logic              wen;

    assign wen = fill_i && (set_i == SET_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (wen) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wen) begin
        t_q <= tag_i;
        d_q <= fill_line_i;
      end
    end

    assign vld_all[g] = v_q;
    assign tag_all[g] = t_q;
    assign dat_all[g] = d_q;
  end

  assign hit_o  = vld_all[set_i] && (tag_all[set_i] == tag_i);
  assign line_o = dat_all[set_i];

  // a freshly filled line is found by the very next lookup of the same key
  p_fill_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |=> (hit_o || !$stable(set_i) || !$stable(tag_i)));

endmodule

// File: rtl/fmap_steer_fsm.sv
module fmap_steer_fsm
  import fmap_steer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit_i,
  input  logic wr_i,
  input  logic dual_i,
  input  logic mem_ready,
  input  logic mem_rvalid,
  input  logic rsp_ready,
  output st_e  st_o,
  output logic load_o,
  output logic fill_o,
  output logic cap_o
);

  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid)  st_d = ST_LOOK;
      ST_LOOK:   if (!hit_i)     st_d = ST_FMREQ;
                 else if (wr_i)  st_d = ST_WRMAIN;
                 else            st_d = ST_RDREQ;
      ST_FMREQ:  if (mem_ready)  st_d = ST_FMWAIT;
      ST_FMWAIT: if (mem_rvalid) st_d = ST_LOOK;
      ST_RDREQ:  if (mem_ready)  st_d = ST_RDWAIT;
      ST_RDWAIT: if (mem_rvalid) st_d = ST_RSP;
      ST_RSP:    if (rsp_ready)  st_d = ST_IDLE;
      ST_WRMAIN: if (mem_ready)  st_d = dual_i ? ST_WRREP : ST_IDLE;
      ST_WRREP:  if (mem_ready)  st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o   = st_q;
  assign load_o = (st_q == ST_IDLE)   && req_valid;
  assign fill_o = (st_q == ST_FMWAIT) && mem_rvalid;
  assign cap_o  = (st_q == ST_RDWAIT) && mem_rvalid;

  // the replica write is only ever reached through the main-copy write
  p_rep_after_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRREP) |-> ($past(st_q) == ST_WRMAIN || $past(st_q) == ST_WRREP));

endmodule

// File: rtl/fmap_steer.sv
module fmap_steer
  import fmap_steer_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 64,
  parameter int          LINE_W   = 512,
  parameter int          TAG_W    = 4,
  parameter int          FMC_SETS = 8,
  parameter logic [31:0] FM_BASE  = 32'hF000_0000,
  localparam int LOFF_W  = $clog2(LINE_W / 8),
  localparam int BOFF_W  = $clog2(DATA_W / 8),
  localparam int WORD_W  = LOFF_W - BOFF_W,
  localparam int LINE_AW = ADDR_W - LOFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [TAG_W-1:0]   req_tag,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic [LINE_AW-1:0] rep_line,
  output logic [WORD_W-1:0]  rep_word,
  input  logic [ADDR_W-1:0]  rep_addr,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_rvalid,
  output logic               mem_rready,
  input  logic [LINE_W-1:0]  mem_rdata
);

  localparam int SLOT_W = $clog2(LINE_W / ENT_W);
  localparam int FML_W  = LINE_AW - SLOT_W;
  localparam int SET_W  = $clog2(FMC_SETS);
  localparam int CTAG_W = FML_W - SET_W;

  st_e  st;
  logic load, fill, cap, hit, dual;

  // captured request
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [TAG_W-1:0]  tag_q;
  logic              wr_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      tag_q   <= req_tag;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) rdata_q <= mem_rdata[DATA_W-1:0];
  end

  // fault-map indexing
  logic [LINE_AW-1:0] line_a;
  logic [FML_W-1:0]   fml;
  logic [SLOT_W-1:0]  slot;
  logic [WORD_W-1:0]  widx;
  logic [LINE_W-1:0]  fm_line;
  logic [ENT_W-1:0]   ent;
  logic [ADDR_W-1:0]  word_addr, fm_addr;
  logic               unused_lo;

  assign line_a    = addr_q[ADDR_W-1:LOFF_W];
  assign fml       = line_a[LINE_AW-1:SLOT_W];
  assign slot      = line_a[SLOT_W-1:0];
  assign widx      = addr_q[LOFF_W-1:BOFF_W];
  assign ent       = fm_line[slot*ENT_W +: ENT_W];
  assign dual      = ent[ENT_W-1] && (ent[WORD_W-1:0] == widx);
  assign word_addr = {addr_q[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
  assign fm_addr   = ADDR_W'(FM_BASE) + {{SLOT_W{1'b0}}, fml, {LOFF_W{1'b0}}};
  assign unused_lo = ^addr_q[BOFF_W-1:0];

  fmap_cache #(
    .SETS   (FMC_SETS),
    .CTAG_W (CTAG_W),
    .LINE_W (LINE_W)
  ) u_cache (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (fml[SET_W-1:0]),
    .tag_i       (fml[FML_W-1:SET_W]),
    .fill_i      (fill),
    .fill_line_i (mem_rdata),
    .hit_o       (hit),
    .line_o      (fm_line)
  );

  fmap_steer_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .hit_i      (hit),
    .wr_i       (wr_q),
    .dual_i     (dual),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .rsp_ready  (rsp_ready),
    .st_o       (st),
    .load_o     (load),
    .fill_o     (fill),
    .cap_o      (cap)
  );

  // port drive
  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RSP);
  assign rsp_rdata  = rdata_q;
  assign rsp_tag    = tag_q;
  assign rep_line   = line_a;
  assign rep_word   = widx;
  assign mem_valid  = (st == ST_FMREQ) || (st == ST_RDREQ) ||
                      (st == ST_WRMAIN) || (st == ST_WRREP);
  assign mem_write  = (st == ST_WRMAIN) || (st == ST_WRREP);
  assign mem_wdata  = wdata_q;
  assign mem_rready = (st == ST_FMWAIT) || (st == ST_RDWAIT);

  always_comb begin
    unique case (st)
      ST_FMREQ: mem_addr = fm_addr;
      ST_RDREQ: mem_addr = dual ? rep_addr : word_addr;
      ST_WRREP: mem_addr = rep_addr;
      default:  mem_addr = word_addr;
    endcase
  end

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_tag)));

  p_single_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !rsp_valid && !mem_rready));

  p_fetch_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_addr >= ADDR_W'(FM_BASE) && !mem_write) |=> !rsp_valid);

endmodule

// File: tb/fmap_steer_tb_top.sv
module fmap_steer_tb_top;

  localparam logic [31:0] FMB = 32'hF000_0000;
  localparam logic [31:0] RPB = 32'hE000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic [3:0]   req_tag = '0;
  logic         req_ready, rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [63:0]  rsp_rdata;
  logic [3:0]   rsp_tag;
  logic [25:0]  rep_line;
  logic [2:0]   rep_word;
  logic [31:0]  rep_addr;
  logic         mem_valid, mem_write, mem_rready;
  logic         mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic [511:0] mem_rdata = '0;

  always #10 clk = ~clk;

  assign rep_addr = RPB + {rep_line, rep_word, 3'b000};

  fmap_steer dut_i (.*);

  int total = 0, bad = 0;

  // ---------- reference functions ----------
  function automatic logic [3:0] fm_ent(logic [25:0] line);
    logic [31:0] h;
    h = {6'b0, line} * 32'h9E37_79B1;
    return {h[23], h[26:24]};
  endfunction

  function automatic logic [511:0] fm_data(logic [18:0] fl);
    logic [511:0] d;
    for (int i = 0; i < 128; i++) d[i*4 +: 4] = fm_ent({fl, 7'(i)});
    return d;
  endfunction

  function automatic logic is_rep(logic [31:0] a);
    logic [3:0] e;
    e = fm_ent(a[31:6]);
    return e[3] && (e[2:0] == a[5:3]);
  endfunction

  function automatic logic [63:0] dflt(logic [31:0] a);
    return {a, ~a} ^ 64'h5A5A_1234_C3C3_0F0F;
  endfunction

  // ---------- memory model and logs ----------
  logic [63:0] phys [logic [31:0]];
  logic [63:0] expv [logic [31:0]];
  logic        pend = 1'b0;
  logic [511:0] pend_d;
  int          n_fetch, n_rd, n_wr, early_data, hold_err = 0;
  logic [31:0] fetch_a, rd_a;
  logic [31:0] wr_a [2];
  logic [63:0] wr_d [2];
  logic        rsp_got;
  logic [63:0] rsp_d;
  logic [3:0]  rsp_t;
  logic        pm_v = 0, pm_r = 0, pm_w = 0, pr_v = 0, pr_r = 0;
  logic [31:0] pm_a = 0;
  logic [63:0] pm_d = 0, pr_d = 0;
  logic [3:0]  pr_t = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pm_v && !pm_r &&
          !(mem_valid && mem_addr == pm_a && mem_write == pm_w && mem_wdata == pm_d))
        hold_err++;
      if (pr_v && !pr_r && !(rsp_valid && rsp_rdata == pr_d && rsp_tag == pr_t))
        hold_err++;
      mem_ready = ($urandom % 10) < 7;
      rsp_ready = ($urandom % 10) < 6;
      if (pend && ($urandom % 3) != 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = pend_d;
        if (mem_rready) pend = 1'b0;
      end else begin
        mem_rvalid = 1'b0;
      end
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          if (n_wr < 2) begin wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; end
          n_wr++;
          phys[mem_addr] = mem_wdata;
        end else if (mem_addr >= FMB) begin
          if (n_rd + n_wr > 0) early_data++;
          n_fetch++;
          fetch_a = mem_addr;
          pend = 1'b1;
          pend_d = fm_data(19'((mem_addr - FMB) >> 6));
        end else begin
          n_rd++;
          rd_a = mem_addr;
          pend = 1'b1;
          if (mem_addr >= RPB)
            pend_d = {448'd0, phys.exists(mem_addr) ? phys[mem_addr] : dflt(mem_addr - RPB)};
          else if (is_rep(mem_addr))
            pend_d = {448'd0, 64'hBAD0_BAD0_BAD0_BAD0};
          else
            pend_d = {448'd0, phys.exists(mem_addr) ? phys[mem_addr] : dflt(mem_addr)};
        end
      end
      if (rsp_valid && rsp_ready) begin
        rsp_got = 1'b1; rsp_d = rsp_rdata; rsp_t = rsp_tag;
      end
      pm_v = mem_valid; pm_r = mem_ready; pm_a = mem_addr; pm_w = mem_write; pm_d = mem_wdata;
      pr_v = rsp_valid; pr_r = rsp_ready; pr_d = rsp_rdata; pr_t = rsp_tag;
    end
  end

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // bench copy of the fault-map cache state, built from R4
  logic        bv [8];
  logic [15:0] bt [8];

  task automatic do_req(input logic wr, input logic [31:0] a, input logic [63:0] d,
                        input logic [3:0] tg);
    logic [18:0] fl;
    logic        miss, rep;
    logic [31:0] main_a, rep_a;
    logic [63:0] ev;
    fl     = a[31:13];
    miss   = !(bv[fl[2:0]] && bt[fl[2:0]] == fl[18:3]);
    bv[fl[2:0]] = 1'b1;
    bt[fl[2:0]] = fl[18:3];
    rep    = is_rep(a);
    main_a = {a[31:3], 3'b000};
    rep_a  = RPB + main_a;
    ev     = expv.exists(main_a) ? expv[main_a] : dflt(main_a);
    if (wr) expv[main_a] = d;
    @(negedge clk);
    n_fetch = 0; n_rd = 0; n_wr = 0; early_data = 0; rsp_got = 1'b0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_tag = tg;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(n_fetch == (miss ? 1 : 0), "R3", "fetch count", 64'(n_fetch), 64'(miss));
    chk(early_data == 0, "R3", "data before fetch", 64'(early_data), 0);
    if (miss) chk(fetch_a == FMB + {7'd0, fl, 6'd0}, "R2", "fetch addr",
                  64'(fetch_a), 64'(FMB + {7'd0, fl, 6'd0}));
    if (!wr) begin
      chk(n_rd == 1, rep ? "R7" : "R6", "read count", 64'(n_rd), 1);
      chk(rd_a == (rep ? rep_a : main_a), rep ? "R7" : "R6", "read addr",
          64'(rd_a), 64'(rep ? rep_a : main_a));
      chk(rsp_got && rsp_d == ev, rep ? "R7" : "R5", "read data", rsp_d, ev);
      chk(rsp_t == tg, "R10", "tag", 64'(rsp_t), 64'(tg));
    end else begin
      chk(!rsp_got, "R8", "write response", 64'(rsp_got), 0);
      chk(n_wr == (rep ? 2 : 1), rep ? "R9" : "R8", "write count",
          64'(n_wr), 64'(rep ? 2 : 1));
      chk(wr_a[0] == main_a && wr_d[0] == d, rep ? "R9" : "R8", "first write addr",
          64'(wr_a[0]), 64'(main_a));
      if (rep) chk(wr_a[1] == rep_a && wr_d[1] == d, "R9", "second write addr",
                   64'(wr_a[1]), 64'(rep_a));
    end
  endtask

  function automatic logic [31:0] mk(logic [18:0] fl, logic [6:0] s, logic [2:0] w);
    return {fl, s, w, 3'b000};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ra, na;
    logic [3:0]  e;
    for (int i = 0; i < 8; i++) begin bv[i] = 1'b0; bt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !mem_valid && !rsp_valid, "R1", "reset idle",
        {61'd0, req_ready, mem_valid, rsp_valid}, 64'd4);
    rst_n = 1'b1;

    // miss then hit in the same fault-map line
    do_req(1'b0, mk(19'd0, 7'd5, 3'd1), '0, 4'h3);
    do_req(1'b0, mk(19'd0, 7'd9, 3'd6), '0, 4'h4);

    // find a replicated word in fault-map line 1 (R5 encoding)
    ra = mk(19'd1, 7'd0, 3'd0);
    for (int s = 0; s < 128; s++) begin
      e = fm_ent({19'd1, 7'(s)});
      if (e[3]) begin ra = mk(19'd1, 7'(s), e[2:0]); break; end
    end
    na = {ra[31:6], ra[5:3] + 3'd1, 3'b000};
    chk(is_rep(ra) && !is_rep(na), "R5", "directed pick", 64'(is_rep(ra)), 1);
    do_req(1'b0, ra, '0, 4'h5);
    do_req(1'b1, ra, 64'h1111_2222_3333_4444, 4'h6);
    do_req(1'b0, ra, '0, 4'h7);
    do_req(1'b1, na, 64'hAAAA_5555_AAAA_5555, 4'h8);
    do_req(1'b0, na, '0, 4'h9);
    // conflict eviction in set 1 (R4)
    do_req(1'b0, mk(19'd9, 7'd3, 3'd2), '0, 4'hA);
    do_req(1'b0, ra, '0, 4'hB);

    for (int k = 0; k < 300; k++) begin
      logic [18:0] fl;
      logic [6:0]  s;
      logic [2:0]  w;
      fl = 19'($urandom % 24);
      s  = 7'($urandom);
      e  = fm_ent({fl, s});
      w  = (($urandom % 2) == 0) ? e[2:0] : 3'($urandom);
      do_req(($urandom % 10) < 4, mk(fl, s, w) | 32'($urandom % 8),
             {$urandom, $urandom}, 4'($urandom));
    end

    chk(hold_err == 0, "R11", "command/response hold", 64'(hold_err), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule